// File: doc/BRIEF.md
# Row Readout Timing Sequencer

This block drives the row-by-row control strobes of a column-parallel pixel array. A row period is split into a fixed number of steps. Each step lasts a programmable number of master-clock cycles, so a 160 MHz clock can be divided down to a 16 MHz step rate. In every step, each strobe copies one bit of its own programmable pattern word. The strobes are row select, reset, clamp, calib sample, read sample and discriminator latch. The power-on strobe uses a pattern twice as long, which covers a pair of neighbouring rows.

A row counter walks through the frame and wraps back to zero at the end. The frame length comes from a programmed last-row field, which is halved in half-array mode and extended by two extra rows in line-marker mode.

Readout starts after the start request is released. The block first waits a fixed number of idle row periods, then begins at row 0. Raising the start request again at any time stops the scan and brings it back to that starting point. The block also provides:
- an analogue sampling clock;
- two row markers at programmable rows;
- frame boundary flags;
- a copy of the power-on strobe delayed by a fixed number of master cycles.

Top module: `rowStrobeGen`

## Requirements
- R1: After reset, and until the start request is first seen high, all strobes, markers and frame flags are 0 and rowIdx is 0.
- R2: On every clock edge where startReq is high, the sequencer is put on hold: all strobes, markers and flags go to 0, and the counters are cleared. This applies at any time, including mid-frame, and resynchronises the frame.
- R3: Call E the first clock edge at which startReq is sampled low after a hold. Row 0, step 0 begins exactly LAT_ROWS × STEPS × DIV master cycles after E. Until then, all outputs stay 0.
- R4: While running, each step lasts DIV master cycles and each row lasts STEPS steps. During step n (n = 0 first), each of the six row strobes equals bit n of its pattern.
- R5: The power strobe uses a 2×STEPS-bit pattern at bit index STEPS×(row mod 2) + n. Even rows therefore use the low half of the pattern and odd rows the high half.
- R6: The last row of the frame is computed as follows. Start from cfgLastRow, or from cfgLastRow shifted right by one when halfMode=1. Then add 2 when lineMark=1. After the last row, the row counter returns to 0 and frames repeat.
- R7: frameFirst is high only during the first master cycle of row 0, step 0. frameLast is high only during the final master cycle of the last step of the last row.
- R8: anaClk is high exactly when the read or calib strobe is high.
- R9: mkAna is high for the whole row whose index equals cfgMarkA, and mkDig for the row equal to cfgMarkD, but only while the scan is running.
- R10: stbPowerDly equals stbPower as it was PWR_DLY master cycles earlier. It is 0 for the first PWR_DLY cycles after reset.
- R11: rowIdx shows the current row while the scan is running and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start / resynchronise request, active high |
| halfMode | input | 1 | Halve the programmed last row |
| lineMark | input | 1 | Append two rows to each frame |
| cfgLastRow | input | ROW_W | Programmed last row index |
| cfgMarkA | input | ROW_W | Row that raises the analogue marker |
| cfgMarkD | input | ROW_W | Row that raises the digital marker |
| patRowSel | input | STEPS | Row-select pattern |
| patReset | input | STEPS | Reset pattern |
| patClamp | input | STEPS | Clamp pattern |
| patCalib | input | STEPS | Calib sample pattern |
| patRead | input | STEPS | Read sample pattern |
| patLatch | input | STEPS | Discriminator latch pattern |
| patPower | input | 2*STEPS | Two-row power-on pattern |
| stbRowSel | output | 1 | Row-select strobe |
| stbReset | output | 1 | Reset strobe |
| stbClamp | output | 1 | Clamp strobe |
| stbCalib | output | 1 | Calib sample strobe |
| stbRead | output | 1 | Read sample strobe |
| stbLatch | output | 1 | Latch strobe |
| stbPower | output | 1 | Power-on strobe |
| stbPowerDly | output | 1 | Power-on strobe delayed by PWR_DLY cycles |
| anaClk | output | 1 | Analogue sampling clock |
| mkAna | output | 1 | Analogue row marker |
| mkDig | output | 1 | Digital row marker |
| rowIdx | output | ROW_W+1 | Current row index |
| frameFirst | output | 1 | First cycle of the frame |
| frameLast | output | 1 | Last cycle of the frame |

## Verification
The hardest situation to reach is a resynchronising start request that arrives in the middle of a running frame, away from any row boundary. In that case the divider, the step counter and the row counter all have to drop to their starting values together, and the latency window has to be served again in full. The stimulus runs the sequence into the middle of a row part-way through a frame, raises the start request for a few cycles, and then follows the restarted scan cycle by cycle against an arithmetic model. The model is driven only by the number of edges since the release. All four combinations of half-array and line-marker mode are swept with two pattern sets. Each run lasts long enough to cross two frame wraps and the odd/even halves of the power pattern.

// File: rtl/rowSeqPkg.sv
package rowSeqPkg;
  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_WAIT, S_RUN} seqState_e;

  // strobes passed from the timer to the pattern datapath
  typedef struct packed {
    logic run;
    logic rowOdd;
    logic frameFirst;
    logic frameLast;
  } seqFlags_t;
endpackage

// File: rtl/rowTimer.sv
module rowTimer
  import rowSeqPkg::*;
#(
  parameter int DIV      = 10,
  parameter int STEPS    = 16,
  parameter int LAT_ROWS = 5,
  parameter int ROW_W    = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic                     halfMode,
  input  logic                     lineMark,
  input  logic [ROW_W-1:0]         cfgLastRow,
  output seqFlags_t                flags,
  output logic [$clog2(STEPS)-1:0] stepIdx,
  output logic [ROW_W:0]           rowIdx
);
  localparam int DIV_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int STEP_W = $clog2(STEPS);
  localparam int LAT_W  = (LAT_ROWS > 1) ? $clog2(LAT_ROWS) : 1;

  seqState_e        state;
  logic [DIV_W-1:0] divCnt;
  logic [STEP_W-1:0] stepCnt;
  logic [LAT_W-1:0] latCnt;
  logic [ROW_W:0]   rowCnt;
  logic [ROW_W:0]   baseLast, frameLastRow;
  logic             divTick, stepEnd, counting;

  assign baseLast     = halfMode ? {2'b00, cfgLastRow[ROW_W-1:1]} : {1'b0, cfgLastRow};
  assign frameLastRow = baseLast + (lineMark ? (ROW_W+1)'(2) : (ROW_W+1)'(0));
  assign divTick      = (divCnt == DIV_W'(DIV - 1));
  assign stepEnd      = (stepCnt == STEP_W'(STEPS - 1));
  assign counting     = (state == S_WAIT) || (state == S_RUN);

  always_ff @(posedge clk) begin
    if (!rstN || startReq) begin
      state   <= rstN ? S_HOLD : S_IDLE;
      divCnt  <= '0;
      stepCnt <= '0;
      latCnt  <= '0;
      rowCnt  <= '0;
    end else if (state == S_HOLD) begin
      state <= S_WAIT;
    end else if (counting) begin
      divCnt <= divTick ? '0 : divCnt + 1'b1;
      if (divTick) begin
        stepCnt <= stepEnd ? '0 : stepCnt + 1'b1;
        if (stepEnd) begin
          if (state == S_WAIT) begin
            if (latCnt == LAT_W'(LAT_ROWS - 1)) begin
              state  <= S_RUN;
              rowCnt <= '0;
            end else begin
              latCnt <= latCnt + 1'b1;
            end
          end else begin
            rowCnt <= (rowCnt >= frameLastRow) ? '0 : rowCnt + 1'b1;
          end
        end
      end
    end
  end

  assign flags.run        = (state == S_RUN);
  assign flags.rowOdd     = rowCnt[0];
  assign flags.frameFirst = flags.run && rowCnt == '0 && stepCnt == '0 && divCnt == '0;
  assign flags.frameLast  = flags.run && rowCnt == frameLastRow && stepEnd && divTick;
  assign stepIdx          = stepCnt;
  assign rowIdx           = flags.run ? rowCnt : '0;

  p_start_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (state == S_HOLD && rowCnt == '0 && stepCnt == '0));

  p_run_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == S_RUN) |-> (stepCnt == '0 && divCnt == '0 && rowCnt == '0));

  p_step_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && !divTick && !startReq) |=> $stable(stepCnt));

  p_frame_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flags.frameLast && !startReq) |=> (rowCnt == '0 && state == S_RUN));

  p_row_adv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && divTick && stepEnd && rowCnt < frameLastRow && !startReq)
      |=> rowCnt == $past(rowCnt) + 1'b1);
endmodule

// File: rtl/strobeMux.sv
module strobeMux
  import rowSeqPkg::*;
#(
  parameter int STEPS   = 16,
  parameter int ROW_W   = 10,
  parameter int PWR_DLY = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqFlags_t                flags,
  input  logic [$clog2(STEPS)-1:0] stepIdx,
  input  logic [ROW_W:0]           rowIdx,
  input  logic [ROW_W-1:0]         cfgMarkA,
  input  logic [ROW_W-1:0]         cfgMarkD,
  input  logic [5:0][STEPS-1:0]    rowPats,
  input  logic [2*STEPS-1:0]       patPower,
  output logic [5:0]               rowStb,
  output logic                     stbPower,
  output logic                     stbPowerDly,
  output logic                     mkAna,
  output logic                     mkDig
);
  localparam int PIDX_W = $clog2(2 * STEPS);

  logic [PIDX_W-1:0]  pwrIdx;
  logic [PWR_DLY-1:0] dlyLine;

  for (genvar g = 0; g < 6; g++) begin : g_rowStb
    assign rowStb[g] = flags.run & rowPats[g][stepIdx];
  end

  assign pwrIdx   = flags.rowOdd ? PIDX_W'(STEPS) + PIDX_W'(stepIdx) : PIDX_W'(stepIdx);
  assign stbPower = flags.run & patPower[pwrIdx];
  assign mkAna    = flags.run && rowIdx == {1'b0, cfgMarkA};
  assign mkDig    = flags.run && rowIdx == {1'b0, cfgMarkD};

  always_ff @(posedge clk) begin
    if (!rstN) dlyLine <= '0;
    else       dlyLine <= {dlyLine[PWR_DLY-2:0], stbPower};
  end
  assign stbPowerDly = dlyLine[PWR_DLY-1];

  p_dly_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stbPower) |=> dlyLine[0]);
endmodule

// File: rtl/rowStrobeGen.sv
module rowStrobeGen
  import rowSeqPkg::*;
#(
  parameter int DIV      = 10,
  parameter int STEPS    = 16,
  parameter int LAT_ROWS = 5,
  parameter int ROW_W    = 10,
  parameter int PWR_DLY  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               halfMode,
  input  logic               lineMark,
  input  logic [ROW_W-1:0]   cfgLastRow,
  input  logic [ROW_W-1:0]   cfgMarkA,
  input  logic [ROW_W-1:0]   cfgMarkD,
  input  logic [STEPS-1:0]   patRowSel,
  input  logic [STEPS-1:0]   patReset,
  input  logic [STEPS-1:0]   patClamp,
  input  logic [STEPS-1:0]   patCalib,
  input  logic [STEPS-1:0]   patRead,
  input  logic [STEPS-1:0]   patLatch,
  input  logic [2*STEPS-1:0] patPower,
  output logic               stbRowSel,
  output logic               stbReset,
  output logic               stbClamp,
  output logic               stbCalib,
  output logic               stbRead,
  output logic               stbLatch,
  output logic               stbPower,
  output logic               stbPowerDly,
  output logic               anaClk,
  output logic               mkAna,
  output logic               mkDig,
  output logic [ROW_W:0]     rowIdx,
  output logic               frameFirst,
  output logic               frameLast
);
  seqFlags_t                flags;
  logic [$clog2(STEPS)-1:0] stepIdx;
  logic [5:0]               rowStb;

  rowTimer #(.DIV(DIV), .STEPS(STEPS), .LAT_ROWS(LAT_ROWS), .ROW_W(ROW_W)) u_timer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .halfMode(halfMode),
    .lineMark(lineMark), .cfgLastRow(cfgLastRow),
    .flags(flags), .stepIdx(stepIdx), .rowIdx(rowIdx)
  );

  strobeMux #(.STEPS(STEPS), .ROW_W(ROW_W), .PWR_DLY(PWR_DLY)) u_mux (
    .clk(clk), .rstN(rstN), .flags(flags), .stepIdx(stepIdx), .rowIdx(rowIdx),
    .cfgMarkA(cfgMarkA), .cfgMarkD(cfgMarkD),
    .rowPats({patLatch, patRead, patCalib, patClamp, patReset, patRowSel}),
    .patPower(patPower), .rowStb(rowStb), .stbPower(stbPower),
    .stbPowerDly(stbPowerDly), .mkAna(mkAna), .mkDig(mkDig)
  );

  assign stbRowSel  = rowStb[0];
  assign stbReset   = rowStb[1];
  assign stbClamp   = rowStb[2];
  assign stbCalib   = rowStb[3];
  assign stbRead    = rowStb[4];
  assign stbLatch   = rowStb[5];
  assign anaClk     = stbRead | stbCalib;
  assign frameFirst = flags.frameFirst;
  assign frameLast  = flags.frameLast;
endmodule

// File: tb/rowStrobeGen_bench.sv
module rowStrobeGen_bench;
  localparam int DIV = 2, STEPS = 16, LAT = 2, ROW_W = 4, PDLY = 16;
  localparam int ROWCYC = DIV * STEPS;
  localparam int LATCYC = LAT * ROWCYC;

  logic clk = 0, rstN = 0, startReq = 0, halfMode = 0, lineMark = 0;
  logic [ROW_W-1:0] cfgLastRow = 4'd9, cfgMarkA = 4'd3, cfgMarkD = 4'd10;
  logic [STEPS-1:0] patRowSel, patReset, patClamp, patCalib, patRead, patLatch;
  logic [2*STEPS-1:0] patPower;
  logic stbRowSel, stbReset, stbClamp, stbCalib, stbRead, stbLatch, stbPower, stbPowerDly;
  logic anaClk, mkAna, mkDig, frameFirst, frameLast;
  logic [ROW_W:0] rowIdx;

  int checks = 0, errors = 0;
  bit done = 0;
  bit seen = 0, held = 0;
  int sinceRel = 0;
  logic [PDLY-1:0] hist = '0;

  always #5 clk = ~clk;

  rowStrobeGen #(.DIV(DIV), .STEPS(STEPS), .LAT_ROWS(LAT), .ROW_W(ROW_W), .PWR_DLY(PDLY)) u_rowStrobeGen (
    .clk(clk), .rstN(rstN), .startReq(startReq), .halfMode(halfMode), .lineMark(lineMark),
    .cfgLastRow(cfgLastRow), .cfgMarkA(cfgMarkA), .cfgMarkD(cfgMarkD),
    .patRowSel(patRowSel), .patReset(patReset), .patClamp(patClamp), .patCalib(patCalib),
    .patRead(patRead), .patLatch(patLatch), .patPower(patPower),
    .stbRowSel(stbRowSel), .stbReset(stbReset), .stbClamp(stbClamp), .stbCalib(stbCalib),
    .stbRead(stbRead), .stbLatch(stbLatch), .stbPower(stbPower), .stbPowerDly(stbPowerDly),
    .anaClk(anaClk), .mkAna(mkAna), .mkDig(mkDig), .rowIdx(rowIdx),
    .frameFirst(frameFirst), .frameLast(frameLast)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic int frameLen();
    int base = halfMode ? (int'(cfgLastRow) >> 1) : int'(cfgLastRow);
    return base + 1 + (lineMark ? 2 : 0);
  endfunction

  // one clock: model update at the edge, compare at the following negedge
  task automatic cyc();
    int t, row, step, ph, fl, pw;
    bit run;
    string ptag;
    @(posedge clk);
    if (startReq) begin seen = 1; held = 1; sinceRel = 0; end
    else if (seen) begin held = 0; sinceRel++; end
    @(negedge clk);
    t   = sinceRel - 1 - LATCYC;
    run = seen && !held && t >= 0;
    pw  = 0;
    if (!run) begin
      ptag = !seen ? "R1" : (held ? "R2" : "R3");
      chk(ptag, {stbRowSel, stbReset, stbClamp, stbCalib, stbRead, stbLatch, stbPower,
                 anaClk, mkAna, mkDig, frameFirst, frameLast}, 0);
      chk("R11", int'(rowIdx), 0);
    end else begin
      fl   = frameLen();
      row  = (t / ROWCYC) % fl;
      step = (t % ROWCYC) / DIV;
      ph   = t % DIV;
      pw   = int'(patPower[(row % 2) * STEPS + step]);
      chk("R4", {stbRowSel, stbReset, stbClamp, stbCalib, stbRead, stbLatch},
          {patRowSel[step], patReset[step], patClamp[step], patCalib[step], patRead[step], patLatch[step]});
      chk("R5", int'(stbPower), pw);
      chk("R6 R11", int'(rowIdx), row);
      chk("R7", {frameFirst, frameLast},
          {row == 0 && step == 0 && ph == 0, row == fl - 1 && step == STEPS - 1 && ph == DIV - 1});
      chk("R8", int'(anaClk), int'(patRead[step] | patCalib[step]));
      chk("R9", {mkAna, mkDig}, {row == int'(cfgMarkA), row == int'(cfgMarkD)});
    end
    chk("R10", int'(stbPowerDly), int'(hist[PDLY-1]));
    hist = {hist[PDLY-2:0], 1'(pw)};
  endtask

  task automatic restart(input int holdCycles);
    startReq = 1;
    for (int i = 0; i < holdCycles; i++) cyc();
    startReq = 0;
  endtask

  initial begin
    patRowSel = 16'h7FFF; patReset = 16'h0040; patClamp = 16'h01C0;
    patCalib  = 16'h3C00; patRead  = 16'h001C; patLatch = 16'h6000;
    patPower  = 32'h7FFF_FFFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: idle before any start request
    for (int i = 0; i < 40; i++) cyc();
    // sweep both pattern sets over every mode combination
    for (int ps = 0; ps < 2; ps++) begin
      if (ps == 1) begin
        patRowSel = 16'hA5C3; patReset = 16'h8001; patClamp = 16'h0FF0;
        patCalib  = 16'h1234; patRead  = 16'hC00C; patLatch = 16'h5555;
        patPower  = 32'hF0F0_0FF1;
      end
      for (int m = 0; m < 4; m++) begin
        halfMode = m[0];
        lineMark = m[1];
        restart(4);
        for (int i = 0; i < LATCYC + 2 * frameLen() * ROWCYC + 20; i++) cyc();
      end
    end
    // R2: resynchronise mid-row, mid-frame
    halfMode = 0; lineMark = 1;
    restart(3);
    for (int i = 0; i < LATCYC + 3 * ROWCYC + 7; i++) cyc();
    restart(5);
    for (int i = 0; i < LATCYC + frameLen() * ROWCYC + 40; i++) cyc();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule